// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block takes one gated power partition from the off state to running in a fixed, safe order. After a start request it asserts the partition reset, stops the partition clock, requests power and waits for the power-good indication. It then enables the clock and keeps it running for a timed settling interval while the outputs stay clamped. Next it asks the clamp logic to release the outputs and waits for the acknowledgement. Last, it releases the reset. The power switch and the clamp cells are outside the block and are reached only through request/acknowledge handshakes.

When a wait times out, or when power-good drops after it has been seen, the sequencer unwinds the steps it has taken in reverse order. It then raises a sticky error flag. A fault before the clock was re-enabled only asserts reset and removes the power request. A fault after that point first stops the clock and withdraws the unclamp request, then asserts reset, then removes the power request. The settling interval and the timeout are given in microseconds and turned into cycle counts from a clock-frequency parameter.

Top module: `part_wake_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `part_rst_o`=1 and `clk_en_o`, `pwr_req_o`, `unclamp_req_o`, `done_o`, `err_o` are all 0.
- R2: A start sampled at edge 1 while idle gives reset asserted after edge 1. Clock enable and unclamp request are cleared after edge 2. The power request is raised after edge 3. This holds even when the partition was left running by an earlier sequence.
- R3: `clk_en_o` rises at the first edge after the power request at which `pwr_ok_i` is sampled high, provided this is at most WAIT_CYC = CLK_MHZ*WAIT_US edges after the request rose.
- R4: `unclamp_req_o` rises exactly HOLD_CYC = CLK_MHZ*HOLD_US edges after `clk_en_o` rose, unless power-good is lost first.
- R5: At the first edge in the clamp wait where `clamp_ack_i` is sampled high with `pwr_ok_i` still high, `part_rst_o` falls and `done_o` is high for that one cycle only. An acknowledgement sampled at the WAIT_CYC-th edge still counts.
- R6: If no power-good is seen within WAIT_CYC edges of the request, the clock is never enabled. `pwr_req_o` falls 1 edge after the timeout edge and `err_o` rises 2 edges after it.
- R7: Power-good sampled low during the settling interval or the clamp wait is a failure at that edge f. The same holds for a missing acknowledgement at the WAIT_CYC-th edge of the clamp wait. `clk_en_o` and `unclamp_req_o` fall at f, `pwr_req_o` falls at f+2 and `err_o` rises at f+3, with reset held throughout. Power-good loss wins over an acknowledgement at the same edge.
- R8: `err_o` stays high while idle and clears at the edge that accepts the next start.
- R9: `start_i` has no effect while a sequence or a rollback is in progress: the output timing is unchanged and `done_o` pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a power-up sequence (taken when idle) |
| pwr_ok_i | input | 1 | Power switch reports partition powered |
| clamp_ack_i | input | 1 | Clamp logic reports outputs released |
| part_rst_o | output | 1 | Partition reset, 1 = held in reset |
| clk_en_o | output | 1 | Partition clock enable |
| pwr_req_o | output | 1 | Request power switch on |
| unclamp_req_o | output | 1 | Request clamp release |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sticky failure flag |

## Verification
The bench sweeps the power-good delay across the timeout boundary, where a design one cycle off would either time out on a late but valid answer or wait one cycle too long. It sweeps the clamp acknowledgement delay across the same boundary and the power-loss instant across the whole settling and clamp window. A wrong priority between loss and acknowledgement would report success on a dying partition, and a wrong rollback would drop power before stopping the clock. A rerun from the running state shows that the clock and unclamp really are withdrawn before power is checked again. Start pulses in mid-sequence would, in a faulty design, restart the steps or give a second done pulse.

// File: rtl/part_wake_pkg.sv
package part_wake_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_CLKOFF,
    ST_PWR,
    ST_HOLD,
    ST_CLAMP,
    ST_REL,
    ST_RB_CLK,
    ST_RB_RST,
    ST_RB_PWR
  } seq_state_e;

endpackage

// File: rtl/part_wake_timer.sv
// Down-counter shared by the settling interval and the handshake timeout.
module part_wake_timer #(
  parameter int HOLD_CYC = 2500,
  parameter int WAIT_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic sel_hold_i,
  output logic expired_o
);

  localparam int MAX_CYC = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= sel_hold_i ? CW'(HOLD_CYC - 1) : CW'(WAIT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // the loaded value is a count of remaining edges, never above the window
  assert_cnt_window_R4 : assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q <= CW'(MAX_CYC - 1)));

endmodule

// File: rtl/part_wake_ctrl.sv
// Step controller with registered partition-facing outputs.
module part_wake_ctrl
  import part_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pwr_ok_i,
  input  logic clamp_ack_i,
  input  logic tmr_expired_i,
  output logic tmr_load_o,
  output logic tmr_sel_hold_o,
  output logic part_rst_o,
  output logic clk_en_o,
  output logic pwr_req_o,
  output logic unclamp_req_o,
  output logic done_o,
  output logic err_o
);

  seq_state_e state_q, state_d;
  logic part_rst_q, clk_en_q, pwr_req_q, unclamp_q, done_q, err_q;

  always_comb begin
    state_d        = state_q;
    tmr_load_o     = 1'b0;
    tmr_sel_hold_o = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_RST;
      ST_RST:    state_d = ST_CLKOFF;
      ST_CLKOFF: begin
        state_d    = ST_PWR;
        tmr_load_o = 1'b1;
      end
      ST_PWR: begin
        if (pwr_ok_i) begin
          state_d        = ST_HOLD;
          tmr_load_o     = 1'b1;
          tmr_sel_hold_o = 1'b1;
        end else if (tmr_expired_i) begin
          state_d = ST_RB_RST;
        end
      end
      ST_HOLD: begin
        if (!pwr_ok_i) begin
          state_d = ST_RB_CLK;
        end else if (tmr_expired_i) begin
          state_d    = ST_CLAMP;
          tmr_load_o = 1'b1;
        end
      end
      ST_CLAMP: begin
        if (!pwr_ok_i)          state_d = ST_RB_CLK;
        else if (clamp_ack_i)   state_d = ST_REL;
        else if (tmr_expired_i) state_d = ST_RB_CLK;
      end
      ST_REL:    state_d = ST_IDLE;
      ST_RB_CLK: state_d = ST_RB_RST;
      ST_RB_RST: state_d = ST_RB_PWR;
      ST_RB_PWR: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // each output changes on the edge that enters the step owning it
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      part_rst_q <= 1'b1;
      clk_en_q   <= 1'b0;
      pwr_req_q  <= 1'b0;
      unclamp_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (state_d != state_q) begin
        unique case (state_d)
          ST_RST:    begin part_rst_q <= 1'b1; err_q <= 1'b0; end
          ST_CLKOFF: begin clk_en_q <= 1'b0; unclamp_q <= 1'b0; end
          ST_PWR:    pwr_req_q <= 1'b1;
          ST_HOLD:   clk_en_q <= 1'b1;
          ST_CLAMP:  unclamp_q <= 1'b1;
          ST_REL:    begin part_rst_q <= 1'b0; done_q <= 1'b1; end
          ST_RB_CLK: begin clk_en_q <= 1'b0; unclamp_q <= 1'b0; end
          ST_RB_RST: part_rst_q <= 1'b1;
          ST_RB_PWR: pwr_req_q <= 1'b0;
          ST_IDLE:   if (state_q == ST_RB_PWR) err_q <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  assign part_rst_o    = part_rst_q;
  assign clk_en_o      = clk_en_q;
  assign pwr_req_o     = pwr_req_q;
  assign unclamp_req_o = unclamp_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  assert_clk_after_pwr_ok_R3 : assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_q) |-> $past(pwr_ok_i));

  assert_unclamp_needs_clock_R4 : assert property (@(posedge clk) disable iff (rst)
    $rose(unclamp_q) |-> (clk_en_q && pwr_req_q));

  assert_release_last_R5 : assert property (@(posedge clk) disable iff (rst)
    $fell(part_rst_q) |-> (done_q && unclamp_q && clk_en_q && pwr_req_q));

  assert_done_single_R5 : assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_err_after_unwind_R6 : assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> (!pwr_req_q && !clk_en_q && !unclamp_q && part_rst_q));

  assert_power_off_last_R7 : assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_req_q) |-> (!clk_en_q && part_rst_q));

  assert_err_sticky_R8 : assert property (@(posedge clk) disable iff (rst)
    (err_q && !start_i) |=> err_q);

endmodule

// File: rtl/part_wake_seq.sv
module part_wake_seq #(
  parameter int CLK_MHZ = 125,
  parameter int HOLD_US = 20,
  parameter int WAIT_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pwr_ok_i,
  input  logic clamp_ack_i,
  output logic part_rst_o,
  output logic clk_en_o,
  output logic pwr_req_o,
  output logic unclamp_req_o,
  output logic done_o,
  output logic err_o
);

  localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

  logic tmr_load, tmr_sel_hold, tmr_expired;

  part_wake_timer #(
    .HOLD_CYC(HOLD_CYC),
    .WAIT_CYC(WAIT_CYC)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .sel_hold_i(tmr_sel_hold),
    .expired_o (tmr_expired)
  );

  part_wake_ctrl ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .pwr_ok_i      (pwr_ok_i),
    .clamp_ack_i   (clamp_ack_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_sel_hold_o(tmr_sel_hold),
    .part_rst_o    (part_rst_o),
    .clk_en_o      (clk_en_o),
    .pwr_req_o     (pwr_req_o),
    .unclamp_req_o (unclamp_req_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/part_wake_seq_tb.sv
module part_wake_seq_tb_top;

  localparam int CLK_MHZ = 1;
  localparam int HOLD_US = 4;
  localparam int WAIT_US = 10;
  localparam int H   = CLK_MHZ * HOLD_US;
  localparam int T   = CLK_MHZ * WAIT_US;
  localparam int INF = 9999;
  localparam int LEN = 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, pwr_ok_i = 1'b0, clamp_ack_i = 1'b0;
  logic part_rst_o, clk_en_o, pwr_req_o, unclamp_req_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  part_wake_seq #(.CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US), .WAIT_US(WAIT_US)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .pwr_ok_i(pwr_ok_i),
    .clamp_ack_i(clamp_ack_i), .part_rst_o(part_rst_o), .clk_en_o(clk_en_o),
    .pwr_req_o(pwr_req_o), .unclamp_req_o(unclamp_req_o), .done_o(done_o),
    .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0; pwr_ok_i = 1'b0; clamp_ack_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // pd: power-good delay after request, cd: ack delay after unclamp,
  // dk: power loss delay after clock enable (-1 = never), ign: stray starts
  task automatic run_case(input int pd, input int cd, input int dk, input bit ign);
    int t_pr = INF, t_ce = INF, t_uc = INF, t_cef = INF, t_prf = INF;
    int t_err = INF, t_rf = INF, n_done = 0, t_done = INF, rst_drop = 0;
    int e_ce, e_uc, e_cef, e_prf, e_err, e_rf, e_done, fd, a, to, f;
    do_reset();
    start_i = 1'b1;
    for (int n = 1; n <= LEN; n++) begin
      @(negedge clk);
      if (t_pr == INF && pwr_req_o) t_pr = n;
      if (t_ce == INF && clk_en_o) t_ce = n;
      if (t_ce != INF && t_cef == INF && !clk_en_o) t_cef = n;
      if (t_uc == INF && unclamp_req_o) t_uc = n;
      if (t_pr != INF && t_prf == INF && !pwr_req_o) t_prf = n;
      if (t_err == INF && err_o) t_err = n;
      if (t_rf == INF && !part_rst_o) t_rf = n;
      if (done_o) begin n_done++; t_done = n; end
      start_i = ign && (n >= 2) && (n <= 10);
      pwr_ok_i = (t_pr != INF && pd >= 0 && n - t_pr >= pd) &&
                 !(t_ce != INF && dk >= 0 && n - t_ce >= dk);
      clamp_ack_i = (t_uc != INF && cd >= 0 && n - t_uc >= cd);
    end
    // expected schedule from the requirements
    e_ce = INF; e_uc = INF; e_cef = INF; e_prf = INF; e_err = INF; e_rf = INF; e_done = 0;
    if (!(pd >= 0 && pd <= T - 1)) begin
      e_prf = 3 + T + 1;
      e_err = 3 + T + 2;
    end else begin
      e_ce = 3 + pd + 1;
      fd = (dk >= 0) ? e_ce + dk + 1 : INF;
      f = INF;
      if (fd <= e_ce + H) begin
        f = fd;
      end else begin
        e_uc = e_ce + H;
        a  = (cd >= 0 && cd <= T - 1) ? e_uc + cd + 1 : INF;
        to = e_uc + T;
        if (a < fd && a <= to) begin
          e_rf = a; e_done = 1;
        end else begin
          f = (fd < to) ? fd : to;
        end
      end
      if (f != INF) begin
        e_cef = f; e_prf = f + 2; e_err = f + 3;
      end
    end
    chk(t_pr == 3, "R2 power request edge", t_pr, 3);
    chk(t_ce == e_ce, "R3 clock enable edge", t_ce, e_ce);
    chk(t_uc == e_uc, "R4 unclamp edge", t_uc, e_uc);
    chk(t_rf == e_rf, "R5 reset release edge", t_rf, e_rf);
    chk(n_done == e_done, "R5 done pulse count", n_done, e_done);
    if (e_done == 1) chk(t_done == e_rf, "R5 done with release", t_done, e_rf);
    if (e_ce == INF) chk(t_prf == e_prf && t_err == e_err, "R6 early unwind",
                         t_prf * 100 + t_err, e_prf * 100 + e_err);
    else chk(t_cef == e_cef && t_prf == e_prf && t_err == e_err, "R7 late unwind",
             t_cef * 10000 + t_prf * 100 + t_err, e_cef * 10000 + e_prf * 100 + e_err);
    if (ign) chk(n_done == 1 && t_rf == e_rf, "R9 start ignored while busy", n_done, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    do_reset();
    @(negedge clk);
    chk(part_rst_o && !clk_en_o && !pwr_req_o && !unclamp_req_o && !done_o && !err_o,
        "R1 reset state",
        {part_rst_o, clk_en_o, pwr_req_o, unclamp_req_o, done_o, err_o}, 6'b100000);

    for (int pd = 0; pd <= T + 1; pd++) run_case(pd, 0, -1, 1'b0);
    for (int cd = 0; cd <= T + 1; cd++) run_case(1, cd, -1, 1'b0);
    for (int dk = 0; dk <= H + T + 1; dk++) run_case(1, -1, dk, 1'b0);
    for (int dk = H; dk <= H + 5; dk++) run_case(1, 3, dk, 1'b0);
    run_case(1, 2, -1, 1'b1);

    // R2: rerun from the running state, power-good and ack kept high
    run_case(0, 0, -1, 1'b0);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(part_rst_o && clk_en_o && unclamp_req_o, "R2 reset first on rerun",
        {part_rst_o, clk_en_o, unclamp_req_o}, 3'b111);
    @(negedge clk);
    chk(!clk_en_o && !unclamp_req_o && pwr_req_o, "R2 clock stopped second",
        {clk_en_o, unclamp_req_o, pwr_req_o}, 3'b001);
    @(negedge clk);
    chk(!clk_en_o, "R2 clock off while power checked", clk_en_o, 0);
    @(negedge clk);
    chk(clk_en_o, "R3 clock on after power-good", clk_en_o, 1);
    repeat (H - 1) @(negedge clk);
    chk(!unclamp_req_o, "R4 unclamp not early", unclamp_req_o, 0);
    @(negedge clk);
    chk(unclamp_req_o, "R4 unclamp after hold", unclamp_req_o, 1);
    @(negedge clk);
    chk(!part_rst_o && done_o, "R5 release on held ack", {part_rst_o, done_o}, 2'b01);

    // R8: error holds until the next accepted start
    run_case(-1, 0, -1, 1'b0);
    repeat (6) @(negedge clk);
    chk(err_o, "R8 error held while idle", err_o, 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!err_o && part_rst_o, "R8 error cleared by start", err_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule